// File: doc/BRIEF.md
# Stack-Organized Execution Unit

This block executes a stream of zero-address instructions against an operand stack held inside the block and a data memory held outside it. Two instructions name a memory word. One loads that word onto the stack and the other stores the top entry back to memory. The two arithmetic instructions name no operand at all. Each one removes the two topmost entries, combines them and leaves the single result on top, so the depth falls by one.

A sequencer upstream hands over one instruction at a time through a valid/ready handshake. The unit drives a synchronous single-port memory that has one cycle of read latency, so a load holds off the next instruction for one extra cycle. Misuse of the stack is reported through two sticky flags, and the misused instruction has no effect. Only a synchronous reset clears the flags.

Top module: `stack_exec_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `instr_ready` is 1, `busy` is 0, both error flags are 0 and neither memory strobe is asserted. The stack is empty after reset.
- R2: An accepted load (`instr_op` = 2'b00) on a stack that is not full asserts `mem_rd_en` with `mem_addr` equal to `instr_addr` in the accepting cycle. In the next cycle `busy` is 1 and `instr_ready` is 0. The word read then becomes the new top, and the unit is ready again one cycle later.
- R3: An accepted store (`instr_op` = 2'b01) on a non-empty stack asserts `mem_wr_en` in the accepting cycle, with `mem_addr` equal to `instr_addr` and `mem_wdata` equal to the top entry. It removes that entry and never makes `busy` rise.
- R4: An accepted add (`instr_op` = 2'b10) with at least two entries replaces them with their sum modulo 2^16 in one cycle.
- R5: An accepted multiply (`instr_op` = 2'b11) with at least two entries replaces them with the low 16 bits of their product in one cycle.
- R6: Entries leave the stack in the reverse of the order in which they were loaded.
- R7: The program load A, load B, add, load C, load D, add, multiply, store X writes (A+B)*(C+D) to word X and leaves the stack empty.
- R8: An add or multiply issued with fewer than two entries sets `underflow_flag`, writes no memory and leaves the stack unchanged.
- R9: A store issued on an empty stack sets `underflow_flag` and asserts no memory strobe.
- R10: A load issued when 8 entries are held sets `overflow_flag`, asserts no memory strobe, does not make `busy` rise and leaves the stack unchanged.
- R11: Both flags stay set through later valid instructions until reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit accepts an instruction this cycle |
| instr_op | input | 2 | 00 load, 01 store, 10 add, 11 multiply |
| instr_addr | input | 8 | Memory word for load/store |
| mem_addr | output | 8 | Memory word address |
| mem_rd_en | output | 1 | Memory read strobe, data returned next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| busy | output | 1 | Load in progress, waiting for read data |
| overflow_flag | output | 1 | Sticky: load on a full stack |
| underflow_flag | output | 1 | Sticky: too few entries for an instruction |

## Verification
The stack itself has no port, so a wrong depth counter or a wrong entry becomes visible only when a later store writes the wrong word to memory. It can also show up as an error flag that rises when it should not, or stays low when it should rise. The depth can therefore be in error for a whole sequence of loads and arithmetic before a store exposes it. For this reason the bench empties the stack completely after each scenario and compares every word that is stored. A wrong handshake state appears at once: `busy` or `instr_ready` takes the wrong value in the cycle after the load is accepted.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_ADD   = 2'b10,
        OP_MUL   = 2'b11
    } stk_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_LOAD
    } stk_state_e;

    typedef struct packed {
        logic push;    // write returned read data on top
        logic pop;     // drop top entry
        logic fold;    // replace top two with ALU result
        logic rd;      // memory read strobe
        logic wr;      // memory write strobe
        logic ovf_set;
        logic unf_set;
    } stk_ctl_t;

    function automatic logic is_arith(stk_op_e op);
        return (op == OP_ADD) || (op == OP_MUL);
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  stk_op_e            op,
    input  logic [DATA_W-1:0]  lhs,
    input  logic [DATA_W-1:0]  rhs,
    output logic [DATA_W-1:0]  res
);
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] prod_w;

    assign sum_w  = lhs + rhs;
    assign prod_w = lhs * rhs;   // low half kept by context width

    always_comb begin
        res = sum_w;
        if (op == OP_MUL) res = prod_w;
    end
endmodule

// File: rtl/stk_store.sv
module stk_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_en,
    input  logic              fold_en,
    input  logic [DATA_W-1:0] fold_data,
    output logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] below,
    output logic              full,
    output logic              has_one,
    output logic              has_two
);
    logic [CNT_W-1:0]  depth_q;
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (push_en && depth_q == CNT_W'(i)) begin
                slot_q[i] <= push_data;
            end else if (fold_en && depth_q == CNT_W'(i + 2)) begin
                slot_q[i] <= fold_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else if (push_en) begin
            depth_q <= depth_q + 1'b1;
        end else if (pop_en || fold_en) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    always_comb begin
        top   = '0;
        below = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth_q == CNT_W'(i + 1)) top   = slot_q[i];
            if (depth_q == CNT_W'(i + 2)) below = slot_q[i];
        end
    end

    assign full    = (depth_q == CNT_W'(DEPTH));
    assign has_one = (depth_q != '0);
    assign has_two = (depth_q > CNT_W'(1));
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     instr_valid,
    input  stk_op_e  op,
    input  logic     full,
    input  logic     has_one,
    input  logic     has_two,
    output logic     instr_ready,
    output logic     busy,
    output stk_ctl_t ctl,
    output logic     ovf_flag,
    output logic     unf_flag
);
    stk_state_e state_q, state_d;
    logic       take;

    assign instr_ready = (state_q == ST_IDLE);
    assign busy        = (state_q == ST_LOAD);
    assign take        = instr_valid && instr_ready;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        if (state_q == ST_LOAD) begin
            ctl.push = 1'b1;
            state_d  = ST_IDLE;
        end else if (take) begin
            unique case (op)
                OP_LOAD: begin
                    if (full) begin
                        ctl.ovf_set = 1'b1;
                    end else begin
                        ctl.rd  = 1'b1;
                        state_d = ST_LOAD;
                    end
                end
                OP_STORE: begin
                    if (!has_one) begin
                        ctl.unf_set = 1'b1;
                    end else begin
                        ctl.wr  = 1'b1;
                        ctl.pop = 1'b1;
                    end
                end
                default: begin
                    if (is_arith(op) && has_two) ctl.fold    = 1'b1;
                    else                         ctl.unf_set = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctl.ovf_set) ovf_flag <= 1'b1;
            if (ctl.unf_set) unf_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [1:0]        instr_op,
    input  logic [ADDR_W-1:0] instr_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              overflow_flag,
    output logic              underflow_flag
);
    stk_op_e           op;
    stk_ctl_t          ctl;
    logic              full, has_one, has_two;
    logic [DATA_W-1:0] top, below, alu_res;

    assign op = stk_op_e'(instr_op);

    stk_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .op          (op),
        .full        (full),
        .has_one     (has_one),
        .has_two     (has_two),
        .instr_ready (instr_ready),
        .busy        (busy),
        .ctl         (ctl),
        .ovf_flag    (overflow_flag),
        .unf_flag    (underflow_flag)
    );

    stk_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (op),
        .lhs (below),
        .rhs (top),
        .res (alu_res)
    );

    stk_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push_en   (ctl.push),
        .push_data (mem_rdata),
        .pop_en    (ctl.pop),
        .fold_en   (ctl.fold),
        .fold_data (alu_res),
        .top       (top),
        .below     (below),
        .full      (full),
        .has_one   (has_one),
        .has_two   (has_two)
    );

    assign mem_addr  = instr_addr;
    assign mem_rd_en = ctl.rd;
    assign mem_wr_en = ctl.wr;
    assign mem_wdata = top;
endmodule

// File: rtl/stack_exec_chk.sv
module stack_exec_chk (
    input logic       clk,
    input logic       rst,
    input logic       instr_valid,
    input logic       instr_ready,
    input logic [1:0] instr_op,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic       busy,
    input logic       overflow_flag,
    input logic       underflow_flag
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (instr_ready && !busy && !overflow_flag && !underflow_flag));

    // R2
    load_stall_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> (busy && !instr_ready));

    // R2
    load_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R2
    rd_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (instr_valid && instr_ready && instr_op == 2'b00));

    // R3
    store_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> !busy);

    // R3
    wr_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (instr_valid && instr_ready && instr_op == 2'b01));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd_en, mem_wr_en}));

    // R10
    ovf_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_ready && instr_op == 2'b00 && !mem_rd_en) |=> overflow_flag);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow_flag |=> overflow_flag);

    // R11
    unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow_flag |=> underflow_flag);
endmodule

bind stack_exec_unit stack_exec_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .instr_valid    (instr_valid),
    .instr_ready    (instr_ready),
    .instr_op       (instr_op),
    .mem_rd_en      (mem_rd_en),
    .mem_wr_en      (mem_wr_en),
    .busy           (busy),
    .overflow_flag  (overflow_flag),
    .underflow_flag (underflow_flag)
);

// File: tb/tb_stack_exec_unit.sv
module tb_stack_exec_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] C_LOAD = 2'b00, C_STORE = 2'b01, C_ADD = 2'b10, C_MUL = 2'b11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [1:0]  instr_op = 2'b00;
    logic [7:0]  instr_addr = '0;
    logic [7:0]  mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        busy, overflow_flag, underflow_flag;

    logic [15:0] mem [256];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_waddr = '0;
    logic [15:0] tb_wdata = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        cap_rd, cap_wr, cap_ready, cap_busy, cap_ready_after;
    logic [7:0]  cap_addr;
    logic [15:0] cap_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_exec_unit dut (
        .clk(clk), .rst(rst),
        .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_op(instr_op), .instr_addr(instr_addr),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .overflow_flag(overflow_flag), .underflow_flag(underflow_flag)
    );

    always @(posedge clk) begin
        if (tb_we)          mem[tb_waddr] <= tb_wdata;
        else if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en)      mem_rdata <= mem[mem_addr];
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(logic [7:0] a, logic [15:0] d);
        @(negedge clk); tb_we = 1'b1; tb_waddr = a; tb_wdata = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic issue(logic [1:0] op, logic [7:0] a);
        @(negedge clk);
        instr_valid = 1'b1; instr_op = op; instr_addr = a;
        #1;
        cap_rd = mem_rd_en; cap_wr = mem_wr_en; cap_ready = instr_ready;
        cap_addr = mem_addr; cap_wdata = mem_wdata;
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        cap_busy = busy; cap_ready_after = instr_ready;
        if (busy) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic expect_pop(string req, logic [7:0] a, logic [15:0] exp);
        issue(C_STORE, a);
        check({req, " store strobe"}, 32'(cap_wr), 32'd1);
        check({req, " store data"}, 32'(cap_wdata), 32'(exp));
        check({req, " memory word"}, 32'(mem[a]), 32'(exp));
    endtask

    task automatic t_reset();
        #1;
        check("R1 ready", 32'(instr_ready), 32'd1);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 flags", {30'd0, overflow_flag, underflow_flag}, 32'd0);
        check("R1 strobes", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
    endtask

    task automatic t_load_store();
        poke(8'd10, 16'h1234);
        issue(C_LOAD, 8'd10);
        check("R2 rd strobe", 32'(cap_rd), 32'd1);
        check("R2 rd addr", 32'(cap_addr), 32'd10);
        check("R2 busy next", 32'(cap_busy), 32'd1);
        check("R2 ready low", 32'(cap_ready_after), 32'd0);
        check("R2 ready back", 32'(instr_ready), 32'd1);
        issue(C_STORE, 8'd50);
        check("R3 addr", 32'(cap_addr), 32'd50);
        check("R3 no stall", 32'(cap_busy), 32'd0);
        check("R3 data", 32'(cap_wdata), 32'h1234);
        check("R3 memory", 32'(mem[50]), 32'h1234);
        check("R3 flags", {30'd0, overflow_flag, underflow_flag}, 32'd0);
    endtask

    task automatic t_lifo();
        poke(8'd1, 16'h0aaa); poke(8'd2, 16'h0bbb); poke(8'd3, 16'h0ccc);
        issue(C_LOAD, 8'd1); issue(C_LOAD, 8'd2); issue(C_LOAD, 8'd3);
        expect_pop("R6 first", 8'd60, 16'h0ccc);
        expect_pop("R6 second", 8'd61, 16'h0bbb);
        expect_pop("R6 third", 8'd62, 16'h0aaa);
    endtask

    task automatic t_add();
        poke(8'd20, 16'hfff0); poke(8'd21, 16'h0020);
        issue(C_LOAD, 8'd20); issue(C_LOAD, 8'd21);
        issue(C_ADD, 8'd0);
        check("R4 no strobe", {30'd0, cap_rd, cap_wr}, 32'd0);
        check("R4 no stall", 32'(cap_busy), 32'd0);
        expect_pop("R4 wrap sum", 8'd70, 16'h0010);
        check("R4 no underflow", 32'(underflow_flag), 32'd0);
    endtask

    task automatic t_mul();
        poke(8'd22, 16'h1234); poke(8'd23, 16'h0100);
        issue(C_LOAD, 8'd22); issue(C_LOAD, 8'd23); issue(C_MUL, 8'd0);
        check("R5 no stall", 32'(cap_busy), 32'd0);
        expect_pop("R5 shift product", 8'd71, 16'h3400);
        poke(8'd24, 16'd300); poke(8'd25, 16'd300);
        issue(C_LOAD, 8'd24); issue(C_LOAD, 8'd25); issue(C_MUL, 8'd0);
        expect_pop("R5 truncated product", 8'd72, 16'd24464);
    endtask

    task automatic t_expr();
        poke(8'd100, 16'd3); poke(8'd101, 16'd4);
        poke(8'd102, 16'd5); poke(8'd103, 16'd6);
        poke(8'd200, 16'hdead);
        issue(C_LOAD, 8'd100); issue(C_LOAD, 8'd101); issue(C_ADD, 8'd0);
        issue(C_LOAD, 8'd102); issue(C_LOAD, 8'd103); issue(C_ADD, 8'd0);
        issue(C_MUL, 8'd0);
        expect_pop("R7 result", 8'd110, 16'd77);
        check("R7 no flags", {30'd0, overflow_flag, underflow_flag}, 32'd0);
        issue(C_STORE, 8'd200);
        check("R7 stack empty", 32'(underflow_flag), 32'd1);
        check("R9 no write", 32'(cap_wr), 32'd0);
        check("R9 memory kept", 32'(mem[200]), 32'hdead);
    endtask

    task automatic t_arith_underflow();
        do_reset();
        poke(8'd30, 16'h0007);
        issue(C_ADD, 8'd0);
        check("R8 empty add", 32'(underflow_flag), 32'd1);
        issue(C_LOAD, 8'd30);
        issue(C_MUL, 8'd0);
        check("R8 no strobe", {30'd0, cap_rd, cap_wr}, 32'd0);
        expect_pop("R8 stack unchanged", 8'd80, 16'h0007);
        check("R8 no overflow", 32'(overflow_flag), 32'd0);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 9; i++) poke(8'(40 + i), 16'(16'h0100 + i));
        for (int i = 0; i < 8; i++) issue(C_LOAD, 8'(40 + i));
        check("R10 no flag yet", 32'(overflow_flag), 32'd0);
        issue(C_LOAD, 8'd48);
        check("R10 flag", 32'(overflow_flag), 32'd1);
        check("R10 no read", 32'(cap_rd), 32'd0);
        check("R10 no stall", 32'(cap_busy), 32'd0);
        for (int i = 7; i >= 0; i--) expect_pop("R10 contents", 8'(150 + i), 16'(16'h0100 + i));
        check("R10 no underflow", 32'(underflow_flag), 32'd0);
    endtask

    task automatic t_sticky();
        poke(8'd5, 16'h0055);
        issue(C_LOAD, 8'd5);
        expect_pop("R11 later op", 8'd90, 16'h0055);
        check("R11 overflow held", 32'(overflow_flag), 32'd1);
        issue(C_STORE, 8'd91);
        issue(C_LOAD, 8'd5);
        expect_pop("R11 op after underflow", 8'd92, 16'h0055);
        check("R11 underflow held", 32'(underflow_flag), 32'd1);
        do_reset();
        #1;
        check("R11 reset clears", {30'd0, overflow_flag, underflow_flag}, 32'd0);
        issue(C_STORE, 8'd93);
        check("R1 stack empty after reset", 32'(cap_wr), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_store();
        t_lifo();
        t_add();
        t_mul();
        t_expr();
        t_arith_underflow();
        t_overflow();
        t_sticky();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule